// File: doc/BRIEF.md
# Three-in-a-Row High Detector

This block watches a single serial bit and raises a flag once that bit has been captured high on three successive rising clock edges. The machine's state is a record of the most recent input samples. Each edge shifts the record one place and puts the current input in the newest slot. The flag is the AND of every slot. Because of this, overlapping runs need no special handling: a run of highs that goes on keeps the flag up, and one low sample clears the newest slot, so three fresh highs are needed again.

A parameter picks how the flag is produced. The plain Moore form decodes the stored history directly. The registered form decodes the history that is about to be stored and captures the result in a flip-flop on the same edge as the history. This avoids a false pulse when several history bits change together (for example 011 going to 110). Both forms show a given result in the same cycle.

Top module: `triple_high_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the history is cleared and `detect` is low in the cycle after that edge.
- R2: `detect` is high in the cycle after an edge exactly when the input was sampled high on that edge and on the two edges before it, all of them after reset was released.
- R3: A run of exactly two high samples followed by a low sample never raises `detect`.
- R4: While the input keeps being sampled high, `detect` stays high for every cycle after the third high of the run.
- R5: A low sample drops `detect` in the next cycle. After that, three new high samples are needed before it rises again.
- R6: With `REG_OUT` = 1 the flag comes from a flip-flop loaded from the next history. It is cycle-identical to the `REG_OUT` = 0 form for any input stream.
- R7: Highs sampled while `rst` is asserted do not count toward a run. After reset is released, three high samples are needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input bit, sampled on each rising edge |
| detect | output | 1 | High when the last RUN_LEN samples were all high |

## Verification
The hardest case to reach is a multi-bit state change that takes the history into or past the all-ones state. Examples are 011 to 110 on a low input, or a run that ends one sample short and then restarts. The stimulus covers this with directed streams: two highs then a low, a high-low-high-high-high pattern, a reset asserted in the middle of a run while the input is held high, and a long run. It then adds several thousand random samples weighted toward highs, so that runs of two, three and more occur often. Both output forms are driven side by side and checked every cycle against a run-length counter kept in the bench.

// File: rtl/thd_pkg.sv
package thd_pkg;
  // Default number of consecutive high samples that form a match.
  localparam int unsigned DEFAULT_RUN_LEN = 3;
endpackage

// File: rtl/thd_shift_next.sv
// Next-history logic: shift the history toward older slots, insert din at slot 0.
module thd_shift_next #(
  parameter int unsigned RUN_LEN = thd_pkg::DEFAULT_RUN_LEN
) (
  input  logic               rst,
  input  logic               din,
  input  logic [RUN_LEN-1:0] hist_q,
  output logic [RUN_LEN-1:0] hist_next
);
  always_comb begin
    if (rst) begin
      hist_next = '0;
    end else begin
      hist_next = {hist_q[RUN_LEN-2:0], din};
    end
  end
endmodule

// File: rtl/thd_hist_reg.sv
// History storage: one flip-flop per remembered sample.
module thd_hist_reg #(
  parameter int unsigned RUN_LEN = thd_pkg::DEFAULT_RUN_LEN
) (
  input  logic               clk,
  input  logic [RUN_LEN-1:0] hist_next,
  output logic [RUN_LEN-1:0] hist_q
);
  always_ff @(posedge clk) begin
    hist_q <= hist_next;
  end
endmodule

// File: rtl/thd_match.sv
// All-ones decoder for a history word.
module thd_match #(
  parameter int unsigned RUN_LEN = thd_pkg::DEFAULT_RUN_LEN
) (
  input  logic [RUN_LEN-1:0] hist,
  output logic               hit
);
  assign hit = &hist;
endmodule

// File: rtl/triple_high_detect.sv
module triple_high_detect #(
  parameter int unsigned RUN_LEN = thd_pkg::DEFAULT_RUN_LEN,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic detect
);
  localparam int unsigned HW = RUN_LEN;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_next;

  thd_shift_next #(.RUN_LEN(HW)) u_next (
    .rst       (rst),
    .din       (din),
    .hist_q    (hist_q),
    .hist_next (hist_next)
  );

  thd_hist_reg #(.RUN_LEN(HW)) u_hist (
    .clk       (clk),
    .hist_next (hist_next),
    .hist_q    (hist_q)
  );

  generate
    if (REG_OUT) begin : g_reg_flag
      // Decode the upcoming history and store the flag on the same edge as the state.
      logic hit_next;
      logic flag_q;
      thd_match #(.RUN_LEN(HW)) u_match (
        .hist (hist_next),
        .hit  (hit_next)
      );
      always_ff @(posedge clk) begin
        flag_q <= hit_next;
      end
      assign detect = flag_q;
    end else begin : g_comb_flag
      // Plain Moore decode of the stored history.
      logic hit_now;
      thd_match #(.RUN_LEN(HW)) u_match (
        .hist (hist_q),
        .hit  (hit_now)
      );
      assign detect = hit_now;
    end
  endgenerate
endmodule

// File: rtl/triple_high_detect_chk.sv
module triple_high_detect_chk #(
  parameter int unsigned RUN_LEN = thd_pkg::DEFAULT_RUN_LEN
) (
  input logic clk,
  input logic rst,
  input logic din,
  input logic detect
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  logic [CW-1:0] run_cnt;

  // Saturating count of consecutive high samples since reset.
  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (din) run_cnt <= (run_cnt == CW'(RUN_LEN)) ? run_cnt : run_cnt + 1'b1;
    else run_cnt <= '0;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !detect);
  assert_flag_tracks_run_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (detect == (run_cnt == CW'(RUN_LEN))));
  assert_rise_needs_high_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> (run_cnt == CW'(RUN_LEN)));
  assert_run_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (detect && din) |=> detect);
  assert_low_drops_R5: assert property (@(posedge clk) disable iff (rst)
    !din |=> !detect);
endmodule

bind triple_high_detect triple_high_detect_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .din    (din),
  .detect (detect)
);

// File: tb/triple_high_detect_tb.sv
`timescale 1ns/1ps
module triple_high_detect_tb;
  localparam int RUN_LEN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic det_reg, det_comb;

  int checks = 0;
  int failures = 0;
  int model_cnt = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  triple_high_detect #(.RUN_LEN(RUN_LEN), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .din(din), .detect(det_reg));
  triple_high_detect #(.RUN_LEN(RUN_LEN), .REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .din(din), .detect(det_comb));

  // Driver: apply one sample at the falling edge and queue the expected flag after the next rise.
  task automatic drive(input bit r, input bit b, input string tag);
    @(negedge clk);
    rst = r;
    din = b;
    if (r) model_cnt = 0;
    else if (b) model_cnt = (model_cnt >= RUN_LEN) ? RUN_LEN : model_cnt + 1;
    else model_cnt = 0;
    exp_q.push_back(model_cnt >= RUN_LEN);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare both output forms shortly after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (det_reg !== e) begin
        failures++;
        $display("FAIL %s registered form: actual=%b expected=%b", t, det_reg, e);
      end
      checks++;
      if (det_comb !== e) begin
        failures++;
        $display("FAIL %s plain form: actual=%b expected=%b", t, det_comb, e);
      end
      checks++;
      if (det_reg !== det_comb) begin
        failures++;
        $display("FAIL R6 forms differ: actual=%b expected=%b", det_reg, det_comb);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    drive(1, 0, "R1");
    drive(1, 1, "R1");
    // R7: highs sampled during reset do not count
    drive(0, 1, "R7");
    drive(0, 1, "R7");
    drive(0, 0, "R3");
    // R3: exactly two highs then low
    drive(0, 1, "R3");
    drive(0, 1, "R3");
    drive(0, 0, "R3");
    // R2: three highs
    drive(0, 1, "R2");
    drive(0, 1, "R2");
    drive(0, 1, "R2");
    // R4: long run
    for (int i = 0; i < 10; i++) drive(0, 1, "R4");
    // R5: low drops, then fresh run
    drive(0, 0, "R5");
    drive(0, 1, "R5");
    drive(0, 1, "R5");
    drive(0, 0, "R5");
    drive(0, 1, "R5");
    drive(0, 1, "R5");
    drive(0, 1, "R5");
    // R7: reset in mid-run with input high
    drive(1, 1, "R7");
    drive(0, 1, "R7");
    drive(0, 1, "R7");
    drive(0, 1, "R7");
    drive(0, 1, "R7");
    // Random stream weighted toward highs
    for (int i = 0; i < 4000; i++) begin
      bit r;
      bit b;
      r = ($urandom_range(0, 199) == 0);
      b = ($urandom_range(0, 99) < 70);
      drive(r, b, "R2");
    end
    drive(0, 0, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule